// File: doc/BRIEF.md
# Character-Assembling I/O Buffer

This block sits between a device that moves 6-bit characters and a port that moves 24-bit words. In input mode it collects characters into a word register and tells the processor when a word is ready. In output mode it accepts a word from the processor and hands it out to the device one character per request. Each character travels with a parity bit. The parity is checked on the way in and generated on the way out.

A connect command sets up the buffer. It chooses the direction, the parity sense and how many characters make up one word (one to four). The same command with the connect bit low drops the link at once. A separate drain pulse ends an output transfer cleanly: the characters already held still go out, and then the link closes. The block raises a one-cycle word interrupt each time a word completes. It raises a one-cycle record interrupt each time a transfer ends on its own. A sticky error flag records parity failures and characters that had to be dropped.

Top module: `chpack_buffer`

## Requirements
- R1: After reset `active`, `wd_loaded`, `err_flag`, `wd_ready` and both interrupts are low. A cycle with `cmd_valid` and `cmd_connect`=1 latches `cmd_dir_out` (1 = output), `cmd_bcd` and `cmd_cpw`. The word count is `cmd_cpw`+1, so 00 gives one character and 11 gives four. That cycle also clears the word register and the character count. `cmd_valid` with `cmd_connect`=0 drops `active` on the next cycle, discards any partial word and raises no interrupt.
- R2: Parity sense: with `cmd_bcd`=0 the XOR of the six data bits and the parity bit is 1 (odd). With `cmd_bcd`=1 it is 0 (even). Every output character carries generated parity. An input character with wrong parity sets `err_flag` and its six data bits are still stored.
- R3: Character k of a word (k = 0 first) occupies bits [23-6k : 18-6k] of `wd_rdata`. Slots past the programmed count read as zero.
- R4: In input mode, `wd_loaded` is high in the cycle after the strobe that delivers the last character of a word. A `wd_rd` cycle while loaded makes `wd_loaded` low on the next cycle and starts an empty word.
- R5: `ch_eor` in input mode closes the link (`active` low next cycle) and pulses `irq_record`. If one or more characters are held, the word is raised as loaded with its low slots zero. If no characters are held, `wd_loaded` stays low.
- R6: An input strobe that arrives while `wd_loaded` is high is dropped. It sets `err_flag` and leaves `wd_rdata` unchanged.
- R7: In output mode `wd_ready` is high while no word is held. `wd_wr` loads `wd_wdata`. Each `ch_req` gives, one cycle later, `ch_out_valid` with the next character in slot order. After the last one, `wd_ready` returns and `irq_word` pulses.
- R8: A `ch_req` in output mode with no word held returns the all-zero character. Its parity bit is 1 in odd mode and 0 in even mode.
- R9: A `cmd_drain` pulse in output mode blocks new words. The characters already held are still delivered. The cycle after the buffer becomes empty, `active` falls and `irq_record` pulses. If the buffer is already empty, this happens on the cycle after the pulse.
- R10: `irq_word` and `irq_record` are only ever pulsed when `irq_en` was high in the cycle of the event that caused them.
- R11: `err_flag` stays set through new words and new commands until an `err_clr` cycle. If an error and `err_clr` fall in the same cycle, the flag ends up set.
- R12: Character strobes, word writes and requests are ignored while the link is closed or when they belong to the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_connect | input | 1 | 1 = connect, 0 = immediate disconnect |
| cmd_dir_out | input | 1 | 1 = word to characters, 0 = characters to word |
| cmd_bcd | input | 1 | 1 = even parity, 0 = odd parity |
| cmd_cpw | input | 2 | Characters per word minus one |
| cmd_drain | input | 1 | Finish held output characters, then close |
| irq_en | input | 1 | Interrupt enable |
| err_clr | input | 1 | Clears the error flag |
| ch_in_stb | input | 1 | Input character strobe |
| ch_in_data | input | 6 | Input character |
| ch_in_par | input | 1 | Input parity bit |
| ch_eor | input | 1 | End of record from device |
| ch_req | input | 1 | Device asks for an output character |
| ch_out_valid | output | 1 | Output character present |
| ch_out_data | output | 6 | Output character |
| ch_out_par | output | 1 | Generated parity bit |
| wd_rd | input | 1 | Processor takes the assembled word |
| wd_loaded | output | 1 | Assembled word waiting |
| wd_rdata | output | 24 | Word register contents |
| wd_wr | input | 1 | Processor supplies a word |
| wd_wdata | input | 24 | Supplied word |
| wd_ready | output | 1 | Buffer can take a word |
| active | output | 1 | Link connected |
| err_flag | output | 1 | Sticky parity or overrun error |
| irq_word | output | 1 | End-of-word interrupt pulse |
| irq_record | output | 1 | End-of-record interrupt pulse |

## Verification
The checker assumes that a character strobe and an end-of-record never share a cycle. It also assumes a command never shares a cycle with device traffic that it is meant to reset. The stimulus tasks drive one event per clock on the falling edge, so these combinations never reach the design. Under those conditions the properties relate parity on the character output to the latched sense, the fall of the loaded flag after a read, the error set by a dropped character, the quiet immediate disconnect, interrupt gating and the holding of the error flag.

// File: rtl/chpack_pkg.sv
`timescale 1ns/1ps
package chpack_pkg;
  localparam int DEF_CHAR_W = 6;
  localparam int DEF_SLOTS  = 4;

  typedef enum logic {DIR_IN = 1'b0, DIR_OUT = 1'b1} dir_e;
endpackage

// File: rtl/chpack_parity.sv
`timescale 1ns/1ps
// Parity generator: returns the bit that gives the whole character the
// selected sense (even_i=1 even, even_i=0 odd).
module chpack_parity #(
  parameter int W = 6
) (
  input  logic [W-1:0] data_i,
  input  logic         even_i,
  output logic         par_o
);
  assign par_o = (^data_i) ^ ~even_i;
endmodule

// File: rtl/chpack_slots.sv
`timescale 1ns/1ps
// Lane steering: inserts a character into slot sel_i and extracts slot sel_i.
// Slot 0 is the most significant lane of the word.
module chpack_slots #(
  parameter int CHAR_W = 6,
  parameter int SLOTS  = 4,
  localparam int WORD_W = CHAR_W * SLOTS,
  localparam int SEL_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [CHAR_W-1:0] char_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CHAR_W-1:0] char_o
);
  logic [CHAR_W-1:0] lane [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_lane
    localparam int HI = WORD_W - 1 - CHAR_W * g;
    assign lane[g] = word_i[HI -: CHAR_W];
    assign word_o[HI -: CHAR_W] = (sel_i == SEL_W'(g)) ? char_i : word_i[HI -: CHAR_W];
  end

  assign char_o = lane[sel_i];
endmodule

// File: rtl/chpack_buffer.sv
`timescale 1ns/1ps
module chpack_buffer
  import chpack_pkg::*;
#(
  parameter int CHAR_W = DEF_CHAR_W,
  parameter int SLOTS  = DEF_SLOTS,
  localparam int WORD_W = CHAR_W * SLOTS,
  localparam int SEL_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_connect,
  input  logic              cmd_dir_out,
  input  logic              cmd_bcd,
  input  logic [SEL_W-1:0]  cmd_cpw,
  input  logic              cmd_drain,
  input  logic              irq_en,
  input  logic              err_clr,
  input  logic              ch_in_stb,
  input  logic [CHAR_W-1:0] ch_in_data,
  input  logic              ch_in_par,
  input  logic              ch_eor,
  input  logic              ch_req,
  output logic              ch_out_valid,
  output logic [CHAR_W-1:0] ch_out_data,
  output logic              ch_out_par,
  input  logic              wd_rd,
  output logic              wd_loaded,
  output logic [WORD_W-1:0] wd_rdata,
  input  logic              wd_wr,
  input  logic [WORD_W-1:0] wd_wdata,
  output logic              wd_ready,
  output logic              active,
  output logic              err_flag,
  output logic              irq_word,
  output logic              irq_record
);
  // mode and state registers
  logic              active_q, bcd_q, full_q, drain_q, err_q;
  dir_e              dir_q;
  logic [SEL_W-1:0]  cpw_q, cnt_q;
  logic [WORD_W-1:0] word_q;
  logic              irq_word_q, irq_rec_q;
  logic              out_vld_q, out_par_q;
  logic [CHAR_W-1:0] out_data_q;

  // datapath helpers
  logic [WORD_W-1:0] ins_word;
  logic [CHAR_W-1:0] ext_char, nxt_char;
  logic              in_par_exp, out_par_gen, par_bad, last_slot;
  logic              in_mode, out_mode;

  chpack_slots #(.CHAR_W(CHAR_W), .SLOTS(SLOTS)) u_slots (
    .word_i (word_q),
    .sel_i  (cnt_q),
    .char_i (ch_in_data),
    .word_o (ins_word),
    .char_o (ext_char)
  );

  chpack_parity #(.W(CHAR_W)) u_par_in (
    .data_i (ch_in_data),
    .even_i (bcd_q),
    .par_o  (in_par_exp)
  );

  assign nxt_char = full_q ? ext_char : '0;

  chpack_parity #(.W(CHAR_W)) u_par_out (
    .data_i (nxt_char),
    .even_i (bcd_q),
    .par_o  (out_par_gen)
  );

  assign par_bad   = (in_par_exp != ch_in_par);
  assign last_slot = (cnt_q == cpw_q);
  assign in_mode   = active_q && (dir_q == DIR_IN);
  assign out_mode  = active_q && (dir_q == DIR_OUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      dir_q      <= DIR_IN;
      bcd_q      <= 1'b0;
      cpw_q      <= '0;
      cnt_q      <= '0;
      word_q     <= '0;
      full_q     <= 1'b0;
      drain_q    <= 1'b0;
      err_q      <= 1'b0;
      irq_word_q <= 1'b0;
      irq_rec_q  <= 1'b0;
      out_vld_q  <= 1'b0;
      out_data_q <= '0;
      out_par_q  <= 1'b0;
    end else begin
      irq_word_q <= 1'b0;
      irq_rec_q  <= 1'b0;
      out_vld_q  <= 1'b0;
      if (err_clr) err_q <= 1'b0;

      // processor collects an assembled word, also after the link closed
      if ((dir_q == DIR_IN) && full_q && wd_rd) begin
        word_q <= '0;
        cnt_q  <= '0;
        full_q <= 1'b0;
      end

      if (cmd_valid) begin
        active_q <= cmd_connect;
        dir_q    <= cmd_dir_out ? DIR_OUT : DIR_IN;
        bcd_q    <= cmd_bcd;
        cpw_q    <= cmd_cpw;
        word_q   <= '0;
        cnt_q    <= '0;
        full_q   <= 1'b0;
        drain_q  <= 1'b0;
      end else if (in_mode) begin
        if (ch_in_stb) begin
          if (full_q) begin
            err_q <= 1'b1;                  // overrun: character dropped
          end else begin
            word_q <= ins_word;
            if (par_bad) err_q <= 1'b1;
            if (last_slot) begin
              full_q     <= 1'b1;
              cnt_q      <= '0;
              irq_word_q <= irq_en;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end else if (ch_eor) begin
          active_q  <= 1'b0;
          irq_rec_q <= irq_en;
          if (!full_q && (cnt_q != '0)) begin
            full_q <= 1'b1;                 // low slots already zero
            cnt_q  <= '0;
          end
        end
      end else if (out_mode) begin
        if (wd_wr && !full_q && !drain_q) begin
          word_q <= wd_wdata;
          full_q <= 1'b1;
          cnt_q  <= '0;
        end
        if (ch_req) begin
          out_vld_q  <= 1'b1;
          out_data_q <= nxt_char;
          out_par_q  <= out_par_gen;
          if (full_q) begin
            if (last_slot) begin
              full_q     <= 1'b0;
              cnt_q      <= '0;
              irq_word_q <= irq_en;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        if (cmd_drain) drain_q <= 1'b1;
        if (drain_q && !full_q) begin
          active_q  <= 1'b0;
          drain_q   <= 1'b0;
          irq_rec_q <= irq_en;
        end
      end
    end
  end

  assign ch_out_valid = out_vld_q;
  assign ch_out_data  = out_data_q;
  assign ch_out_par   = out_par_q;
  assign wd_loaded    = full_q && (dir_q == DIR_IN);
  assign wd_rdata     = word_q;
  assign wd_ready     = out_mode && !full_q && !drain_q;
  assign active       = active_q;
  assign err_flag     = err_q;
  assign irq_word     = irq_word_q;
  assign irq_record   = irq_rec_q;
endmodule

// File: rtl/chpack_buffer_chk.sv
`timescale 1ns/1ps
module chpack_buffer_chk #(
  parameter int CHAR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_connect,
  input logic              ch_in_stb,
  input logic              wd_rd,
  input logic              irq_en,
  input logic              err_clr,
  input logic              dir_out,
  input logic              bcd,
  input logic              active,
  input logic              wd_loaded,
  input logic              err_flag,
  input logic              irq_word,
  input logic              irq_record,
  input logic              ch_out_valid,
  input logic [CHAR_W-1:0] ch_out_data,
  input logic              ch_out_par
);
  a_r2_out_parity: assert property (@(posedge clk) disable iff (rst)
    ch_out_valid |-> (((^ch_out_data) ^ ch_out_par) != bcd));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
    (wd_loaded && wd_rd) |=> !wd_loaded);

  a_r6_overrun_err: assert property (@(posedge clk) disable iff (rst)
    (wd_loaded && ch_in_stb && active && !dir_out && !cmd_valid) |=> err_flag);

  a_r1_quiet_disconnect: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_connect) |=> (!active && !irq_word && !irq_record));

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> (!irq_word && !irq_record));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag);
endmodule

bind chpack_buffer chpack_buffer_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_valid    (cmd_valid),
  .cmd_connect  (cmd_connect),
  .ch_in_stb    (ch_in_stb),
  .wd_rd        (wd_rd),
  .irq_en       (irq_en),
  .err_clr      (err_clr),
  .dir_out      (dir_q == chpack_pkg::DIR_OUT),
  .bcd          (bcd_q),
  .active       (active),
  .wd_loaded    (wd_loaded),
  .err_flag     (err_flag),
  .irq_word     (irq_word),
  .irq_record   (irq_record),
  .ch_out_valid (ch_out_valid),
  .ch_out_data  (ch_out_data),
  .ch_out_par   (ch_out_par)
);

// File: tb/chpack_buffer_test.sv
`timescale 1ns/1ps
module chpack_buffer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 0, cmd_connect = 0, cmd_dir_out = 0, cmd_bcd = 0, cmd_drain = 0;
  logic [1:0]  cmd_cpw = 0;
  logic        irq_en = 0, err_clr = 0;
  logic        ch_in_stb = 0, ch_in_par = 0, ch_eor = 0, ch_req = 0;
  logic [5:0]  ch_in_data = 0;
  logic        ch_out_valid, ch_out_par;
  logic [5:0]  ch_out_data;
  logic        wd_rd = 0, wd_wr = 0;
  logic        wd_loaded, wd_ready, active, err_flag, irq_word, irq_record;
  logic [23:0] wd_rdata;
  logic [23:0] wd_wdata = 0;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chpack_buffer uut (.*);

  function automatic logic par_of(input logic [5:0] d, input logic even);
    return even ? (^d) : ~(^d);
  endfunction

  function automatic logic [23:0] put_slot(input logic [23:0] w, input int k, input logic [5:0] d);
    logic [23:0] r = w;
    r[23-6*k -: 6] = d;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic connect(input logic dir, input logic bcd, input logic [1:0] cpw);
    cmd_valid = 1; cmd_connect = 1; cmd_dir_out = dir; cmd_bcd = bcd; cmd_cpw = cpw;
    tick(); cmd_valid = 0; cmd_connect = 0;
  endtask

  task automatic disconnect();
    cmd_valid = 1; cmd_connect = 0; tick(); cmd_valid = 0;
  endtask

  task automatic send_raw(input logic [5:0] d, input logic p);
    ch_in_stb = 1; ch_in_data = d; ch_in_par = p; tick(); ch_in_stb = 0;
  endtask

  task automatic send(input logic [5:0] d, input logic bcd);
    send_raw(d, par_of(d, bcd));
  endtask

  task automatic rd();  wd_rd = 1; tick(); wd_rd = 0; endtask
  task automatic eor(); ch_eor = 1; tick(); ch_eor = 0; endtask
  task automatic req(); ch_req = 1; tick(); ch_req = 0; endtask
  task automatic wr(input logic [23:0] w); wd_wr = 1; wd_wdata = w; tick(); wd_wr = 0; endtask

  initial begin
    #800000;
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [23:0] w;
    logic [5:0]  d;
    logic        b;
    logic [1:0]  c;
    void'($urandom(32'd4242));
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    check("R1 reset loaded", wd_loaded, 0);
    check("R1 reset active", active, 0);
    check("R1 reset err", err_flag, 0);
    check("R1 reset ready", wd_ready, 0);

    // R4/R10 directed word with interrupt
    irq_en = 1;
    connect(0, 0, 2'b11);
    send(6'h01, 0); send(6'h02, 0); send(6'h03, 0);
    check("R4 not yet loaded", wd_loaded, 0);
    send(6'h3F, 0);
    check("R4 loaded", wd_loaded, 1);
    check("R10 irq_word on", irq_word, 1);
    check("R3 packed order", wd_rdata, 24'h0420FF);
    rd();
    check("R4 read clears", wd_loaded, 0);

    // R3/R2 random input words
    for (int i = 0; i < 16; i++) begin
      b = 1'($urandom); c = 2'($urandom);
      connect(0, b, c);
      w = 0;
      for (int k = 0; k <= int'(c); k++) begin
        d = 6'($urandom);
        w = put_slot(w, k, d);
        send(d, b);
      end
      check("R3 random word", wd_rdata, w);
      check("R4 random loaded", wd_loaded, 1);
      rd();
    end
    check("R2 good parity no error", err_flag, 0);

    // R2 parity error in even mode, data still stored
    connect(0, 1, 2'b00);
    send_raw(6'h07, 0);
    check("R2 parity error flag", err_flag, 1);
    check("R2 data stored", wd_rdata, 24'h1C0000);
    rd();
    // R11 sticky across command, clear works
    connect(0, 0, 2'b00);
    check("R11 sticky over command", err_flag, 1);
    err_clr = 1; tick(); err_clr = 0;
    check("R11 cleared", err_flag, 0);

    // R6 overrun
    send(6'h2A, 0);
    send(6'h15, 0);
    check("R6 overrun err", err_flag, 1);
    check("R6 word unchanged", wd_rdata, 24'hA80000);
    rd();
    err_clr = 1; tick(); err_clr = 0;
    // R11 set wins over clear
    err_clr = 1; send_raw(6'h00, 0); err_clr = 0;
    check("R11 set beats clear", err_flag, 1);
    rd();
    err_clr = 1; tick(); err_clr = 0;

    // R5 end of record with partial word
    connect(0, 0, 2'b11);
    send(6'h3F, 0); send(6'h01, 0);
    eor();
    check("R5 pad loaded", wd_loaded, 1);
    check("R5 pad word", wd_rdata, 24'hFC1000);
    check("R5 closed", active, 0);
    check("R5 irq_record", irq_record, 1);
    rd();
    check("R4 read after close", wd_loaded, 0);
    connect(0, 0, 2'b11);
    eor();
    check("R5 empty not loaded", wd_loaded, 0);
    check("R5 empty closed", active, 0);

    // R1 immediate disconnect drops partial, no interrupt
    connect(0, 0, 2'b01);
    send(6'h11, 0);
    disconnect();
    check("R1 disconnect active", active, 0);
    check("R1 disconnect no irq", {30'd0, irq_word, irq_record}, 0);
    // R12 ignored while closed
    send(6'h22, 0); send(6'h22, 0);
    check("R12 closed ignores chars", wd_loaded, 0);
    connect(0, 0, 2'b01);
    wr(24'hFFFFFF);
    send(6'h05, 0); send(6'h06, 0);
    check("R12 fresh word only", wd_rdata, 24'h146000);
    rd();

    // R10 gated interrupt
    irq_en = 0;
    connect(0, 0, 2'b00);
    send(6'h09, 0);
    check("R10 irq_word gated", irq_word, 0);
    check("R10 loaded anyway", wd_loaded, 1);
    rd();
    irq_en = 1;

    // R7 output directed and random
    connect(1, 0, 2'b10);
    check("R7 ready empty", wd_ready, 1);
    wr(24'h123456);
    check("R7 ready busy", wd_ready, 0);
    send(6'h3F, 0);
    check("R12 out mode ignores strobe", err_flag, 0);
    req(); check("R7 char0", {ch_out_valid, ch_out_data}, {1'b1, 6'h04});
    req(); check("R7 char1", ch_out_data, 6'h23);
    req(); check("R7 char2", ch_out_data, 6'h11);
    check("R7 irq_word", irq_word, 1);
    check("R7 ready again", wd_ready, 1);
    for (int i = 0; i < 16; i++) begin
      b = 1'($urandom); c = 2'($urandom);
      connect(1, b, c);
      w = 24'($urandom);
      wr(w);
      for (int k = 0; k <= int'(c); k++) begin
        req();
        check("R7 random char", ch_out_data, w[23-6*k -: 6]);
        check("R2 out parity", ch_out_par, par_of(w[23-6*k -: 6], b));
      end
      check("R7 random ready", wd_ready, 1);
    end

    // R8 underrun blanks
    connect(1, 0, 2'b00);
    req();
    check("R8 blank odd", {ch_out_valid, ch_out_data, ch_out_par}, {1'b1, 6'h00, 1'b1});
    connect(1, 1, 2'b00);
    req();
    check("R8 blank even", {ch_out_valid, ch_out_data, ch_out_par}, {1'b1, 6'h00, 1'b0});

    // R9 drain
    connect(1, 0, 2'b01);
    wr(24'hABCDEF);
    cmd_drain = 1; tick(); cmd_drain = 0;
    check("R9 ready blocked", wd_ready, 0);
    req();
    check("R9 still active", active, 1);
    req();
    check("R9 last char", ch_out_data, 6'h3C);
    check("R9 active until empty", active, 1);
    tick();
    check("R9 closed", active, 0);
    check("R9 irq_record", irq_record, 1);
    connect(1, 0, 2'b00);
    cmd_drain = 1; tick(); cmd_drain = 0;
    tick();
    check("R9 empty drain closed", active, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule